// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Controller

This block is the interrupt front end shared by four counter channels. Each channel raises a one-cycle request pulse, and the block holds the pulse as a pending flag. It picks the winning channel by fixed priority, with the lowest channel number winning. It pulls the active-low interrupt line low when the chain above it permits. An enable-in / enable-out pair links it to other peripherals in a priority chain. A device higher in the chain that is being served blocks this block and every device below it.

When the processor runs an acknowledge cycle, the block supplies the winning channel's vector on the data bus and raises a drive enable. An acknowledge cycle is both active-low strobes (`m1N`, `iorqN`) low together. When the acknowledge ends, the channel moves from pending to under-service. It stays under service, and keeps lower devices in the chain blocked, until a decoded return-from-interrupt arrives while the enable-in is high. Nesting is allowed: a higher-priority channel can interrupt while a lower one is still under service.

Top module: `irq_chain_ctl`

## Requirements
- R1: After reset, no channel is pending or under service, `intN` is high, `dataDrive` is low and `ieo` follows `iei`.
- R2: A one-cycle pulse on `reqPulse[i]` sets a pending flag for channel i. While `iei` is high and the channel is not masked, `intN` goes low from the next cycle.
- R3: When several channels are pending, the lowest channel index wins the acknowledge.
- R4: The vector byte is `{vecBase[4:0], channel[1:0], 1'b0}`: bits 7..3 come from the base register, bits 2..1 hold the channel number and bit 0 is zero. The base register is loaded from `vecBaseIn` on a cycle with `vecWe` high.
- R5: `dataDrive` is high, and `vecOut` carries the vector, only while `m1N` and `iorqN` are both low, `iei` is high and a winner was held before the cycle began. Otherwise `dataDrive` is low and `vecOut` is zero.
- R6: When an acknowledge that drove a vector ends, that channel's pending flag clears and its under-service flag sets. `ieo` is low while any channel is under service.
- R7: While `iei` is low, `ieo` is low and `intN` is high whatever is pending.
- R8: A pending channel does not assert `intN` while it, or any lower-index channel, is under service. A pending lower-index channel still asserts it.
- R9: A cycle with `retiSeen` high and `iei` high clears the under-service flag of the lowest-index serviced channel only. With `iei` low, `retiSeen` has no effect. `ieo` returns high once no channel is under service and `iei` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqPulse | input | 4 | Per-channel request pulses |
| vecWe | input | 1 | Load strobe for the vector base |
| vecBaseIn | input | 5 | New vector base bits |
| iei | input | 1 | Chain enable from higher-priority devices |
| m1N | input | 1 | Active-low cycle-type strobe |
| iorqN | input | 1 | Active-low I/O strobe; low with `m1N` marks an acknowledge |
| retiSeen | input | 1 | Decoded return-from-interrupt indication |
| intN | output | 1 | Active-low interrupt request |
| ieo | output | 1 | Chain enable to lower-priority devices |
| vecOut | output | 8 | Vector byte during acknowledge |
| dataDrive | output | 1 | Data-bus drive enable |

## Verification
The hardest state to reach from the ports is nested service. A low channel is under service while a lower-priority request waits masked, a higher-priority request breaks through, and return-from-interrupt arrives both with `iei` low and with it high. The stimulus builds this step by step: it serves channel 2, then requests channel 3 and checks that it stays masked, then requests and serves channel 1. It then checks that only the innermost flag is released on each enabled return, and that a disabled return leaves `ieo` low.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_CH  = 4;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int VEC_W   = 8;
  localparam int BASE_W  = VEC_W - CH_W - 1;

  typedef struct packed {
    logic ackDone;   // acknowledge finished: move granted channel into service
    logic retiClr;   // release innermost serviced channel
  } ctlStrobe_t;
endpackage

// File: rtl/irq_flags_dp.sv
module irq_flags_dp
  import irq_pkg::*;
#(
  parameter int N_CH   = NUM_CH,
  parameter int CHW    = CH_W,
  parameter int BASEW  = BASE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  reqPulse,
  input  logic             vecWe,
  input  logic [BASEW-1:0] vecBaseIn,
  input  ctlStrobe_t       strobe,
  input  logic [CHW-1:0]   grantCh,
  output logic             winValid,
  output logic [CHW-1:0]   winCh,
  output logic             anyService,
  output logic [BASEW-1:0] vecBase
);
  logic [N_CH-1:0] pending, inService;
  logic [N_CH-1:0] ackMask, retMask;
  logic            blocked;

  // one-hot decode of the granted channel
  always_comb begin
    ackMask = '0;
    ackMask[grantCh] = strobe.ackDone;
  end

  // lowest set under-service bit
  assign retMask = strobe.retiClr ? (inService & (~inService + 1'b1)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= '0;
      inService <= '0;
      vecBase   <= '0;
    end else begin
      pending   <= (pending & ~ackMask) | reqPulse;
      inService <= (inService & ~retMask) | ackMask;
      if (vecWe) vecBase <= vecBaseIn;
    end
  end

  // fixed priority: walk from channel 0, stop at first serviced channel
  always_comb begin
    winValid = 1'b0;
    winCh    = '0;
    blocked  = 1'b0;
    for (int i = 0; i < N_CH; i++) begin
      if (inService[i]) blocked = 1'b1;
      if (!blocked && pending[i] && !winValid) begin
        winValid = 1'b1;
        winCh    = CHW'(i);
      end
    end
  end

  assign anyService = |inService;

  // R6: a completed acknowledge leaves its channel under service
  a_r6_ack_sets_service: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.ackDone |=> inService[$past(grantCh)]);

  // R9: one release removes exactly one serviced channel
  a_r9_single_release: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.retiClr && !strobe.ackDone && (inService != '0))
      |=> ($countones(inService) + 1 == $past($countones(inService))));
endmodule

// File: rtl/irq_ack_ctl.sv
module irq_ack_ctl
  import irq_pkg::*;
#(
  parameter int CHW = CH_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           m1N,
  input  logic           iorqN,
  input  logic           iei,
  input  logic           retiSeen,
  input  logic           winValid,
  input  logic [CHW-1:0] winCh,
  output logic [CHW-1:0] grantCh,
  output logic           dataDrive,
  output ctlStrobe_t     strobe
);
  logic ackActive, ackPrev, grantValid, tookGrant;

  assign ackActive = !m1N && !iorqN;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ackPrev    <= 1'b0;
      grantValid <= 1'b0;
      grantCh    <= '0;
      tookGrant  <= 1'b0;
    end else begin
      ackPrev <= ackActive;
      if (!ackActive) begin
        grantValid <= winValid;     // winner frozen for the whole acknowledge
        grantCh    <= winCh;
        tookGrant  <= 1'b0;
      end else if (iei && grantValid) begin
        tookGrant  <= 1'b1;
      end
    end
  end

  assign dataDrive      = ackActive && iei && grantValid;
  assign strobe.ackDone = ackPrev && !ackActive && tookGrant;
  assign strobe.retiClr = retiSeen && iei;

  // R5: the vector does not change while it is being driven
  a_r5_vector_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (dataDrive && $past(dataDrive)) |-> $stable(grantCh));
endmodule

// File: rtl/irq_chain_ctl.sv
module irq_chain_ctl
  import irq_pkg::*;
#(
  parameter int N_CH  = NUM_CH,
  parameter int VECW  = VEC_W,
  localparam int CHW   = $clog2(N_CH),
  localparam int BASEW = VECW - CHW - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_CH-1:0]  reqPulse,
  input  logic             vecWe,
  input  logic [BASEW-1:0] vecBaseIn,
  input  logic             iei,
  input  logic             m1N,
  input  logic             iorqN,
  input  logic             retiSeen,
  output logic             intN,
  output logic             ieo,
  output logic [VECW-1:0]  vecOut,
  output logic             dataDrive
);
  ctlStrobe_t       strobe;
  logic             winValid, anyService;
  logic [CHW-1:0]   winCh, grantCh;
  logic [BASEW-1:0] vecBase;

  irq_flags_dp #(.N_CH(N_CH), .CHW(CHW), .BASEW(BASEW)) uDp (
    .clk(clk), .rst_n(rst_n), .reqPulse(reqPulse), .vecWe(vecWe),
    .vecBaseIn(vecBaseIn), .strobe(strobe), .grantCh(grantCh),
    .winValid(winValid), .winCh(winCh), .anyService(anyService),
    .vecBase(vecBase)
  );

  irq_ack_ctl #(.CHW(CHW)) uCtl (
    .clk(clk), .rst_n(rst_n), .m1N(m1N), .iorqN(iorqN), .iei(iei),
    .retiSeen(retiSeen), .winValid(winValid), .winCh(winCh),
    .grantCh(grantCh), .dataDrive(dataDrive), .strobe(strobe)
  );

  assign intN   = !(iei && winValid);
  assign ieo    = iei && !anyService;
  assign vecOut = dataDrive ? {vecBase, grantCh, 1'b0} : '0;

  // R7: a blocked chain silences this device and everything below
  a_r7_chain_block: assert property (@(posedge clk) disable iff (!rst_n)
    !iei |-> (intN && !ieo));

  // R1: first cycle out of reset is quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ieo == iei));

  // R5: drive only inside an acknowledge
  a_r5_drive_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    dataDrive |-> (!m1N && !iorqN && iei));
endmodule

// File: tb/tb_irq_chain_ctl.sv
module tb_irq_chain_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] reqPulse;
  logic       vecWe;
  logic [4:0] vecBaseIn;
  logic       iei, m1N, iorqN, retiSeen;
  logic       intN, ieo, dataDrive;
  logic [7:0] vecOut;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  irq_chain_ctl dut (
    .clk(clk), .rst_n(rst_n), .reqPulse(reqPulse), .vecWe(vecWe),
    .vecBaseIn(vecBaseIn), .iei(iei), .m1N(m1N), .iorqN(iorqN),
    .retiSeen(retiSeen), .intN(intN), .ieo(ieo), .vecOut(vecOut),
    .dataDrive(dataDrive)
  );

  // stimulus table: request mask, expected winning channel
  typedef struct packed { logic [3:0] mask; logic [1:0] ch; } vecEntry_t;
  localparam vecEntry_t TABLE [8] = '{
    '{4'b0001, 2'd0}, '{4'b0010, 2'd1}, '{4'b0100, 2'd2}, '{4'b1000, 2'd3},
    '{4'b1100, 2'd2}, '{4'b1010, 2'd1}, '{4'b0110, 2'd1}, '{4'b1111, 2'd0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [3:0] m);
    reqPulse = m; step(1); reqPulse = '0; step(1);
  endtask

  // acknowledge: returns sampled drive and vector
  task automatic ack(output logic drv, output logic [7:0] v);
    m1N = 0; iorqN = 0; step(1);
    drv = dataDrive; v = vecOut;
    m1N = 1; iorqN = 1; step(2);
  endtask

  task automatic reti();
    retiSeen = 1; step(1); retiSeen = 0; step(1);
  endtask

  task automatic drain();
    logic d; logic [7:0] v;
    for (int k = 0; k < 8 && !intN; k++) begin ack(d, v); reti(); end
    for (int k = 0; k < 4; k++) reti();
  endtask

  function automatic int vecOf(input logic [4:0] b, input logic [1:0] c);
    return {b, c, 1'b0};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1; fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic d; logic [7:0] v;
    rst_n = 0; reqPulse = 0; vecWe = 0; vecBaseIn = 0; iei = 1;
    m1N = 1; iorqN = 1; retiSeen = 0;
    step(3);
    rst_n = 1; step(1);
    // R1 reset state
    check("R1 intN", intN, 1);
    check("R1 ieo", ieo, 1);
    check("R1 dataDrive", dataDrive, 0);
    // R5 acknowledge with nothing pending drives nothing
    ack(d, v);
    check("R5 idle ack drive", d, 0);
    check("R5 idle ack vec", v, 0);

    vecBaseIn = 5'b10110; vecWe = 1; step(1); vecWe = 0; step(1);

    foreach (TABLE[i]) begin
      pulse(TABLE[i].mask);
      check("R2 intN low", intN, 0);
      ack(d, v);
      check("R5 drive", d, 1);
      check("R3 winner vector", v, vecOf(5'b10110, TABLE[i].ch));
      check("R6 ieo low in service", ieo, 0);
      check("R5 drive off after ack", dataDrive, 0);
      reti();
      check("R9 ieo back high", ieo, (TABLE[i].mask == (4'b1 << TABLE[i].ch)) ? 1 : ieo);
      drain();
      check("R9 drained ieo", ieo, 1);
    end

    // R4 new base
    vecBaseIn = 5'b01001; vecWe = 1; step(1); vecWe = 0; step(1);
    pulse(4'b1000);
    ack(d, v);
    check("R4 vector base", v, 8'h4E);
    reti();
    check("R9 single release ieo", ieo, 1);

    // R8 / R9 nesting
    pulse(4'b0100);
    ack(d, v);
    check("R3 ch2 vector", v, 8'h4C);
    pulse(4'b1000);
    check("R8 ch3 masked by ch2", intN, 1);
    pulse(4'b0010);
    check("R8 ch1 breaks through", intN, 0);
    ack(d, v);
    check("R8 nested vector", v, 8'h4A);
    reti();
    check("R9 ch2 still serviced ieo", ieo, 0);
    check("R9 ch3 still masked", intN, 1);
    iei = 0; step(1);
    reti();
    iei = 1; step(1);
    check("R9 reti ignored with iei low", ieo, 0);
    reti();
    check("R9 last release ieo", ieo, 1);
    check("R9 ch3 now asserts", intN, 0);
    drain();

    // R7 chain blocked
    iei = 0; step(1);
    pulse(4'b0001);
    check("R7 intN held high", intN, 1);
    check("R7 ieo low", ieo, 0);
    ack(d, v);
    check("R7 no drive with iei low", d, 0);
    iei = 1; step(2);
    check("R7 intN after iei high", intN, 0);
    ack(d, v);
    check("R7 vector after release", v, 8'h48);
    reti();
    check("R1 quiet end", intN, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule